// File: doc/BRIEF.md
# Per-Burst CRC Checker with Command-Level Error Latch

This block sits on the device side of a parallel DMA link to a disk. A command's data moves in one or more bursts. A burst runs while the host's acknowledge input is high. Each burst gets a fresh 16-bit CRC, seeded when acknowledge rises. Every data word strobed during the burst is folded into that CRC.

At the end of each burst the host presents its own CRC value with a valid strobe. The block compares that value with its local CRC. A mismatch is not reported at once. It is held as a pending error until the command completes.

When the command ends, the block raises a one-cycle done pulse. In the same cycle it shows the error status. The status is set if any burst of the command failed, and the first failure fixes it. The status then holds until the next command starts. Capturing data from bus strobe edges happens upstream.

Top module: `burst_crc_check`

## Requirements
- R1: Each accepted word updates the CRC with generator x^16 + x^12 + x^5 + 1 (constant 16'h1021). The 16 data bits are shifted in most significant bit first. For each bit, the feedback is the CRC's top bit XOR the data bit, the register shifts left, and the constant is XORed in when the feedback is 1.
- R2: In the cycle where `burst_ack` goes from 0 to 1, the CRC is reloaded with 16'h4ABA. A word strobed in that same cycle is folded into the fresh seed, so no value carries over from an earlier burst.
- R3: A word is accepted only when `word_valid` and `burst_ack` are both 1. Strobes outside a burst leave the CRC unchanged.
- R4: When `host_crc_valid` is 1 during a burst inside an open command, `host_crc` is compared with the CRC of the words accepted in earlier cycles of that burst. A mismatch is held as pending, and `err_status` does not change before the command ends.
- R5: Once any burst of a command has mismatched, the pending error stays set. Later matching bursts of the same command do not clear it.
- R6: `cmd_end` while a command is open (and `cmd_start` low) makes `cmd_done` 1 for exactly one cycle after that edge. `err_status` then shows whether a mismatch occurred, including one flagged in the `cmd_end` cycle itself.
- R7: `err_status` keeps its value until the next `cmd_start`. That edge clears both `err_status` and the pending error. Nothing between bursts clears them.
- R8: A host CRC strobe outside a burst, or while no command is open, has no effect on the error result.
- R9: After reset, `err_status` and `cmd_done` are 0 and no command is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Opens a command; clears status |
| cmd_end | input | 1 | Closes the open command |
| burst_ack | input | 1 | High for the length of a burst |
| word_valid | input | 1 | Data word strobe |
| word_data | input | 16 | Data word |
| host_crc_valid | input | 1 | Host CRC strobe |
| host_crc | input | 16 | Host's CRC for the current burst |
| err_status | output | 1 | Command error result, held until next start |
| cmd_done | output | 1 | One-cycle completion pulse |

## Verification
Single-burst commands of 0 to 8 words are swept over four data patterns. Each is sent once with the bench's own arithmetic CRC and once with one bit flipped. The match case shows the polynomial, bit order and seed are right. A sweep over all 16 flipped bit positions shows every CRC bit takes part in the compare.

Multi-burst commands separate per-burst reseeding from carried-over CRC state. They also show that a failing first burst is not erased by a passing second one. Stray word strobes and stray host CRC strobes outside a burst show which inputs are ignored. Probes before and after `cmd_end` and `cmd_start` show the error result is deferred, held and cleared at the right moments.

// File: rtl/burst_crc_check.sv
module burst_crc_check #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    POLY = 16'h1021,
  parameter logic [W-1:0]    SEED = 16'h4ABA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_start,
  input  logic         cmd_end,
  input  logic         burst_ack,
  input  logic         word_valid,
  input  logic [W-1:0] word_data,
  input  logic         host_crc_valid,
  input  logic [W-1:0] host_crc,
  output logic         err_status,
  output logic         cmd_done
);

  function automatic logic [W-1:0] crc_step(input logic [W-1:0] c, input logic [W-1:0] d);
    logic [W-1:0] r;
    logic         fb;
    r = c;
    for (int i = W - 1; i >= 0; i--) begin
      fb = r[W-1] ^ d[i];
      r  = {r[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  logic         ack_q;
  logic         in_cmd;
  logic         pend_err;
  logic [W-1:0] crc_q;

  wire          ack_rise  = burst_ack & ~ack_q;
  wire [W-1:0]  crc_base  = ack_rise ? SEED : crc_q;
  wire          take_word = burst_ack & word_valid;
  wire          mismatch  = in_cmd & burst_ack & host_crc_valid & (host_crc != crc_base);
  wire          closing   = cmd_end & in_cmd & ~cmd_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      crc_q <= SEED;
    end else begin
      ack_q <= burst_ack;
      crc_q <= take_word ? crc_step(crc_base, word_data) : crc_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cmd     <= 1'b0;
      pend_err   <= 1'b0;
      err_status <= 1'b0;
      cmd_done   <= 1'b0;
    end else begin
      cmd_done <= closing;
      if (cmd_start) begin
        in_cmd     <= 1'b1;
        pend_err   <= 1'b0;
        err_status <= 1'b0;
      end else begin
        if (mismatch) pend_err <= 1'b1;
        if (closing) begin
          in_cmd     <= 1'b0;
          err_status <= pend_err | mismatch;
        end
      end
    end
  end

endmodule

// File: rtl/burst_crc_check_chk.sv
module burst_crc_check_chk #(
  parameter int           W    = 16,
  parameter logic [W-1:0] SEED = 16'h4ABA
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_start,
  input logic         cmd_end,
  input logic         burst_ack,
  input logic         word_valid,
  input logic         err_status,
  input logic         cmd_done,
  input logic [W-1:0] crc_q
);

  logic         p_start, p_end, p_ack, p_rise, p_take, p_err;
  logic [W-1:0] p_crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_start <= 1'b0; p_end <= 1'b0; p_ack <= 1'b0;
      p_rise  <= 1'b0; p_take <= 1'b0; p_err <= 1'b0;
      p_crc   <= SEED;
    end else begin
      p_start <= cmd_start;
      p_end   <= cmd_end;
      p_ack   <= burst_ack;
      p_rise  <= burst_ack & ~p_ack;
      p_take  <= burst_ack & word_valid;
      p_err   <= err_status;
      p_crc   <= crc_q;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_done |=> !cmd_done);
  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_done |-> p_end && !p_start);
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_done && !p_start) |-> err_status == p_err);
  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_start |-> (!err_status && !cmd_done));
  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rise && !p_take) |-> crc_q == SEED);
  // R3
  crc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_rise && !p_take) |-> crc_q == p_crc);

endmodule

bind burst_crc_check burst_crc_check_chk #(.W(W), .SEED(SEED)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_end(cmd_end),
  .burst_ack(burst_ack), .word_valid(word_valid), .err_status(err_status),
  .cmd_done(cmd_done), .crc_q(crc_q)
);

// File: tb/test_burst_crc_check.sv
module test_burst_crc_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_end = 1'b0, burst_ack = 1'b0, word_valid = 1'b0;
  logic        host_crc_valid = 1'b0;
  logic [15:0] word_data = '0, host_crc = '0;
  logic        err_status, cmd_done;

  int checks = 0, fails = 0;
  logic [15:0] wbuf [0:15];

  always #10 clk = ~clk;

  burst_crc_check i_burst_crc_check (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_end(cmd_end),
    .burst_ack(burst_ack), .word_valid(word_valid), .word_data(word_data),
    .host_crc_valid(host_crc_valid), .host_crc(host_crc),
    .err_status(err_status), .cmd_done(cmd_done)
  );

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h4ABA;
    for (int k = 0; k < n; k++)
      for (int b = 15; b >= 0; b--) begin
        logic fb = c[15] ^ wbuf[k][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fill(input int k);
    for (int i = 0; i < 16; i++)
      case (k)
        0: wbuf[i] = 16'h0001 << i;
        1: wbuf[i] = 16'(i * 16'h3779) ^ 16'hA5A5;
        2: wbuf[i] = 16'hFFFF;
        default: wbuf[i] = 16'h0000;
      endcase
  endtask

  task automatic start_cmd();
    cmd_start = 1'b1; step(); cmd_start = 1'b0;
  endtask

  task automatic burst(input int n, input logic [15:0] hc);
    burst_ack = 1'b1;
    for (int i = 0; i < n; i++) begin
      word_valid = 1'b1; word_data = wbuf[i]; step();
    end
    word_valid = 1'b0;
    if (n == 0) step();
    host_crc_valid = 1'b1; host_crc = hc; step();
    host_crc_valid = 1'b0; burst_ack = 1'b0; step();
  endtask

  task automatic end_cmd(input string req, input logic exp_err);
    cmd_end = 1'b1; step(); cmd_end = 1'b0;
    check({req, " done"}, 16'(cmd_done), 16'd1);
    check({req, " err"}, 16'(err_status), 16'(exp_err));
    step();
    check({req, " done drop"}, 16'(cmd_done), 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    // R9 reset state
    check("R9 err", 16'(err_status), 16'd0);
    check("R9 done", 16'(cmd_done), 16'd0);
    rst_n = 1'b1; step();

    // R1 R2 match / mismatch sweep over length and pattern
    for (int k = 0; k < 4; k++)
      for (int n = 0; n <= 8; n++) begin
        fill(k);
        start_cmd(); burst(n, ref_crc(n)); end_cmd("R1 match", 1'b0);
        start_cmd(); burst(n, ref_crc(n) ^ (16'h1 << ((k * 4 + n) % 16)));
        end_cmd("R1 mismatch", 1'b1);
      end

    // R1 every CRC bit takes part
    fill(1);
    for (int b = 0; b < 16; b++) begin
      start_cmd(); burst(3, ref_crc(3) ^ (16'h1 << b)); end_cmd("R1 bitflip", 1'b1);
    end

    // R2 reseed per burst: second burst checked from fresh seed
    fill(1);
    start_cmd(); burst(5, ref_crc(5)); burst(2, ref_crc(2)); end_cmd("R2 reseed", 1'b0);

    // R3 strobes outside a burst ignored
    start_cmd();
    word_valid = 1'b1; word_data = 16'hDEAD; step(); step(); word_valid = 1'b0;
    burst(4, ref_crc(4));
    end_cmd("R3 stray words", 1'b0);

    // R4 deferred report, R5 first failure sticky
    start_cmd();
    burst(3, ~ref_crc(3));
    check("R4 deferred", 16'(err_status), 16'd0);
    burst(3, ref_crc(3));
    check("R4 deferred 2", 16'(err_status), 16'd0);
    end_cmd("R5 sticky", 1'b1);

    // R7 hold across idle cycles and stray bursts after end
    repeat (5) step();
    check("R7 hold", 16'(err_status), 16'd1);
    burst(2, ref_crc(2));
    check("R7 hold after burst", 16'(err_status), 16'd1);
    start_cmd();
    check("R7 clear", 16'(err_status), 16'd0);
    burst(2, ref_crc(2));
    end_cmd("R7 cleared pending", 1'b0);

    // R8 host CRC outside burst / outside command ignored
    start_cmd();
    host_crc_valid = 1'b1; host_crc = 16'h1234; step(); host_crc_valid = 1'b0;
    burst(1, ref_crc(1));
    end_cmd("R8 outside burst", 1'b0);
    burst(1, ~ref_crc(1));
    start_cmd(); burst(1, ref_crc(1)); end_cmd("R8 outside command", 1'b0);

    // R6 mismatch in the cmd_end cycle counts
    start_cmd();
    burst_ack = 1'b1; word_valid = 1'b1; word_data = wbuf[0]; step(); word_valid = 1'b0;
    host_crc_valid = 1'b1; host_crc = ~ref_crc(1); cmd_end = 1'b1; step();
    cmd_end = 1'b0; host_crc_valid = 1'b0; burst_ack = 1'b0;
    check("R6 same-cycle done", 16'(cmd_done), 16'd1);
    check("R6 same-cycle err", 16'(err_status), 16'd1);
    step();
    check("R6 pulse width", 16'(cmd_done), 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule